// File: doc/BRIEF.md
# Twin-Channel Prescaled Pulse-Width Modulator

This block drives two pulse-width modulated pins from one shared 15-bit free-running counter. The counter advances on a tick. A 3-bit source code picks the tick: either one of seven power-of-two divisions of the system clock, or a rising edge of an external clock input after it has been synchronised.

Each channel has its own period length and its own 8-bit duty value. The period is either 256 ticks (fast) or 32768 ticks (slow). A new duty value written by software is held back and only used from the start of that channel's next period. Either pin can be overridden to drive a static level taken from a register bit. Pin A can also carry the selected tick clock in place of its waveform.

Software programs the block through a small write-only register port with four addresses. Both pins are registered, so every pin change appears one system clock after the internal state that causes it.

Top module: `twin_pwm`

## Requirements
- R1: After reset, both pins are low and stay low with no writes. Reset clears the counter, every control bit and both duty values.
- R2: Address 0 bits [2:0] hold the tick source. For codes 0 to 6, the counter advances once every 2^(code+1) system clocks. A fast period with duty D therefore lasts 256·2^(code+1) clocks and is high for D·2^(code+1) clocks.
- R3: Tick source code 7 advances the counter once per rising edge of `ext_clk`.
- R4: In fast mode (address 0 bit 4 for A, bit 5 for B, value 0), a channel's period is 256 ticks and its pin is high for the first D ticks. D is the duty value at address 1 (A) or address 2 (B).
- R5: In slow mode (that bit set to 1), the period is 32768 ticks and the pin is high for the first D·128 ticks.
- R6: A duty value of 0 holds the channel's pin constantly low.
- R7: A duty write does not change the period already running. The new value takes effect from the next period start.
- R8: Address 3 bit 0 (A) or bit 2 (B) forces the pin to the level in bit 1 (A) or bit 3 (B), one clock after the write.
- R9: When the force bit of A and the clock-output bit are both set, pin A shows the forced level, not the clock.
- R10: With address 0 bit 3 set and A not forced, pin A carries the selected tick clock. For code k, that clock is a square wave that is high for 2^k clocks in a period of 2^(k+1) clocks.
- R11: The two channels run independently on the shared counter, each with its own duty value and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 duty A, 2 duty B, 3 override) |
| wr_data | input | 8 | Register write data |
| ext_clk | input | 1 | External tick clock, asynchronous |
| pwm_a_o | output | 1 | Channel A pin |
| pwm_b_o | output | 1 | Channel B pin |

## Verification
The slow period is the hardest case to reach from the ports. It lasts 32768 ticks, and the pin only rises when the whole counter wraps. The bench therefore runs it last, on the fastest tap, and measures one full rise-to-rise interval.

The deferred duty update is the other delicate case. The bench detects a rising edge on pin A and drives the new duty write in that same sampling slot, so the write lands inside the running high phase. It then confirms that the high time still matches the old duty value, and that the next period uses the new one.

// File: rtl/twin_pwm_pkg.sv
package twin_pwm_pkg;
  localparam int SEL_W  = 3;
  localparam int CNT_W  = 15;
  localparam int DUTY_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 2'd0,
    REG_DUTY_A = 2'd1,
    REG_DUTY_B = 2'd2,
    REG_OVR    = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [SEL_W-1:0] src_sel;
    logic             clk_out_en;
    logic             slow_a;
    logic             slow_b;
    logic             force_a;
    logic             level_a;
    logic             force_b;
    logic             level_b;
  } cfg_t;
endpackage

// File: rtl/twin_pwm_regs.sv
module twin_pwm_regs
  import twin_pwm_pkg::*;
#(
  parameter int DATA_W = DUTY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output cfg_t              cfg,
  output logic [DATA_W-1:0] duty_a,
  output logic [DATA_W-1:0] duty_b
);
  cfg_t              cfg_q, cfg_d;
  logic [DATA_W-1:0] duty_a_q, duty_a_d;
  logic [DATA_W-1:0] duty_b_q, duty_b_d;

  always_comb begin
    cfg_d    = cfg_q;
    duty_a_d = duty_a_q;
    duty_b_d = duty_b_q;
    if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        REG_CTRL: begin
          cfg_d.src_sel    = wr_data[SEL_W-1:0];
          cfg_d.clk_out_en = wr_data[SEL_W];
          cfg_d.slow_a     = wr_data[SEL_W+1];
          cfg_d.slow_b     = wr_data[SEL_W+2];
        end
        REG_DUTY_A: duty_a_d = wr_data;
        REG_DUTY_B: duty_b_d = wr_data;
        REG_OVR: begin
          cfg_d.force_a = wr_data[0];
          cfg_d.level_a = wr_data[1];
          cfg_d.force_b = wr_data[2];
          cfg_d.level_b = wr_data[3];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      duty_a_q <= '0;
      duty_b_q <= '0;
    end else begin
      cfg_q    <= cfg_d;
      duty_a_q <= duty_a_d;
      duty_b_q <= duty_b_d;
    end
  end

  assign cfg    = cfg_q;
  assign duty_a = duty_a_q;
  assign duty_b = duty_b_q;
endmodule

// File: rtl/twin_pwm_tick.sv
module twin_pwm_tick
#(
  parameter int SEL_W = twin_pwm_pkg::SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             ext_clk,
  output logic             tick,
  output logic             sel_clk
);
  localparam int               TAPS     = (1 << SEL_W) - 1;
  localparam logic [SEL_W-1:0] EXT_CODE = SEL_W'(TAPS);

  logic [TAPS-1:0] div_q, div_d;
  logic [1:0]      sync_q, sync_d;
  logic            prev_q, prev_d;
  logic [TAPS-1:0] tap_tick;
  logic [TAPS-1:0] tap_lvl;
  logic            ext_rise;

  // Tap g fires once every 2^(g+1) clocks, when the low g+1 divider bits are all ones.
  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    assign tap_tick[g] = &div_q[g:0];
    assign tap_lvl[g]  = div_q[g];
  end

  always_comb begin
    div_d  = div_q + 1'b1;
    sync_d = {sync_q[0], ext_clk};
    prev_d = sync_q[1];
  end

  assign ext_rise = sync_q[1] & ~prev_q;

  always_comb begin
    if (src_sel == EXT_CODE) begin
      tick    = ext_rise;
      sel_clk = sync_q[1];
    end else begin
      tick    = tap_tick[src_sel];
      sel_clk = tap_lvl[src_sel];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/twin_pwm_chan.sv
module twin_pwm_chan
#(
  parameter int CNT_W  = twin_pwm_pkg::CNT_W,
  parameter int DUTY_W = twin_pwm_pkg::DUTY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              slow,
  input  logic [CNT_W-1:0]  cnt_nxt,
  input  logic [DUTY_W-1:0] duty_wr,
  output logic              pwm,
  output logic              prd_start,
  output logic [DUTY_W-1:0] duty_act
);
  logic [DUTY_W-1:0] act_q, act_d;
  logic              out_q, out_d;
  logic [DUTY_W-1:0] fld;
  logic              wrap;

  // Compared field: top counter bits in slow mode, low bits in fast mode.
  always_comb begin
    fld  = slow ? cnt_nxt[CNT_W-1 -: DUTY_W] : cnt_nxt[DUTY_W-1:0];
    wrap = slow ? (cnt_nxt == '0) : (cnt_nxt[DUTY_W-1:0] == '0);
  end

  assign prd_start = tick & wrap;

  always_comb begin
    act_d = act_q;
    out_d = out_q;
    if (prd_start) begin
      act_d = duty_wr;
      out_d = |duty_wr;
    end else if (tick && (fld == act_q)) begin
      out_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      out_q <= 1'b0;
    end else begin
      act_q <= act_d;
      out_q <= out_d;
    end
  end

  assign pwm      = out_q;
  assign duty_act = act_q;
endmodule

// File: rtl/twin_pwm.sv
module twin_pwm
  import twin_pwm_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int DW = DUTY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              ext_clk,
  output logic              pwm_a_o,
  output logic              pwm_b_o
);
  localparam int NCH = 2;

  cfg_t          cfg;
  logic [DW-1:0] duty_a, duty_b;
  logic          tick, sel_clk;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] duty_wr  [NCH];
  logic [DW-1:0] duty_act [NCH];
  logic [NCH-1:0] slow, pwm, start;
  logic [NCH-1:0] pin_q, pin_d;

  twin_pwm_regs #(.DATA_W(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg(cfg), .duty_a(duty_a), .duty_b(duty_b)
  );

  twin_pwm_tick #(.SEL_W(SEL_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .src_sel(cfg.src_sel), .ext_clk(ext_clk),
    .tick(tick), .sel_clk(sel_clk)
  );

  always_comb cnt_d = tick ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign slow       = {cfg.slow_b, cfg.slow_a};
  assign duty_wr[0] = duty_a;
  assign duty_wr[1] = duty_b;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    twin_pwm_chan #(.CNT_W(CW), .DUTY_W(DW)) u_chan (
      .clk(clk), .rst_n(rst_n), .tick(tick), .slow(slow[c]),
      .cnt_nxt(cnt_d), .duty_wr(duty_wr[c]), .pwm(pwm[c]),
      .prd_start(start[c]), .duty_act(duty_act[c])
    );
  end

  // Force beats clock output, which beats the waveform.
  always_comb begin
    pin_d[0] = cfg.force_a ? cfg.level_a : (cfg.clk_out_en ? sel_clk : pwm[0]);
    pin_d[1] = cfg.force_b ? cfg.level_b : pwm[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin_d;
  end

  assign pwm_a_o = pin_q[0];
  assign pwm_b_o = pin_q[1];
endmodule

// File: rtl/twin_pwm_chk.sv
module twin_pwm_chk
#(
  parameter int CW = twin_pwm_pkg::CNT_W,
  parameter int DW = twin_pwm_pkg::DUTY_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic [CW-1:0] cnt_q,
  input logic          force_a,
  input logic          level_a,
  input logic          force_b,
  input logic          level_b,
  input logic          clk_out_en,
  input logic [DW-1:0] duty_act_a,
  input logic          start_a,
  input logic          pwm_a_o,
  input logic          pwm_b_o
);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt_q == $past(cnt_q) + 1'b1);

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

  // R8
  force_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_a |=> pwm_a_o == $past(level_a));

  // R8
  force_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_b |=> pwm_b_o == $past(level_b));

  // R9
  force_over_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_a && clk_out_en) |=> pwm_a_o == $past(level_a));

  // R6
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_a && !clk_out_en && duty_act_a == '0) |=> !pwm_a_o);

  // R7
  duty_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act_a != $past(duty_act_a)) |-> $past(start_a));
endmodule

bind twin_pwm twin_pwm_chk #(.CW(CW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_q(cnt_q),
  .force_a(cfg.force_a), .level_a(cfg.level_a),
  .force_b(cfg.force_b), .level_b(cfg.level_b),
  .clk_out_en(cfg.clk_out_en), .duty_act_a(duty_act[0]),
  .start_a(start[0]), .pwm_a_o(pwm_a_o), .pwm_b_o(pwm_b_o)
);

// File: tb/twin_pwm_bench.sv
module twin_pwm_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       ext_clk;
  logic       pwm_a_o, pwm_b_o;
  bit         ext_run = 1'b0;
  int         n_chk = 0;
  int         n_bad = 0;

  always #10 clk = ~clk;

  twin_pwm u_twin_pwm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ext_clk(ext_clk), .pwm_a_o(pwm_a_o), .pwm_b_o(pwm_b_o)
  );

  typedef struct {
    int    ch;
    int    hi;
    int    per;
    string tag;
  } exp_t;

  exp_t exp_q[$];

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic pin(input int ch);
    return (ch != 0) ? pwm_b_o : pwm_a_o;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rise(input int ch, output bit ok);
    logic prev;
    ok = 1'b0;
    @(negedge clk);
    prev = pin(ch);
    for (int i = 0; i < 140000; i++) begin
      @(negedge clk);
      if (!prev && pin(ch)) begin
        ok = 1'b1;
        break;
      end
      prev = pin(ch);
    end
  endtask

  task automatic hold(input int ch, input logic lvl, input int n, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pin(ch) !== lvl) bad++;
    end
    chk(tag, bad, 0);
  endtask

  // Driver side of the scoreboard: queue one expected waveform, wait until consumed.
  task automatic expect_wave(input int ch, input int hi, input int per, input string tag);
    exp_t e;
    e.ch = ch; e.hi = hi; e.per = per; e.tag = tag;
    exp_q.push_back(e);
    wait (exp_q.size() == 0);
  endtask

  // Monitor: measure high time and rise-to-rise period for each queued item.
  initial begin : monitor
    exp_t e;
    bit   ok;
    bit   seen_low;
    int   hi, per;
    forever begin
      wait (exp_q.size() > 0);
      e = exp_q[0];
      wait_rise(e.ch, ok);
      hi = -1; per = -1;
      if (ok) begin
        hi = 1; per = 1; seen_low = 1'b0;
        for (int i = 0; i < 140000; i++) begin
          @(negedge clk);
          if (pin(e.ch)) begin
            if (seen_low) break;
            hi++;
          end else begin
            seen_low = 1'b1;
          end
          per++;
        end
      end
      chk({e.tag, " high"}, hi, e.hi);
      chk({e.tag, " period"}, per, e.per);
      void'(exp_q.pop_front());
    end
  end

  // External clock: toggles every 3 system clocks, rising edge every 6.
  initial begin : ext_gen
    int cnt = 0;
    ext_clk = 1'b0;
    forever begin
      @(negedge clk);
      if (ext_run) begin
        cnt++;
        if (cnt == 3) begin
          cnt = 0;
          ext_clk = ~ext_clk;
        end
      end
    end
  end

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual expired expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    bit ok;
    int hi;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state and quiet pins
    @(negedge clk);
    chk("R1 pin A after reset", int'(pwm_a_o), 0);
    chk("R1 pin B after reset", int'(pwm_b_o), 0);
    hold(0, 1'b0, 600, "R1 pin A idle low");
    hold(1, 1'b0, 600, "R1 pin B idle low");

    // R4 / R2: fast mode, divide by 2
    wr(2'd1, 8'd64);
    wr(2'd0, 8'h00);
    expect_wave(0, 128, 512, "R4 fast duty 64 div2");

    // R2: divide by 8
    wr(2'd1, 8'd10);
    wr(2'd0, 8'h02);
    expect_wave(0, 80, 2048, "R2 code2 div8");

    // R11: channel B independent, divide by 4
    wr(2'd2, 8'd200);
    wr(2'd0, 8'h01);
    expect_wave(1, 800, 1024, "R11 channel B duty 200");
    expect_wave(0, 40, 1024, "R11 channel A duty 10");

    // R6: zero duty
    wr(2'd1, 8'd0);
    repeat (1100) @(negedge clk);
    hold(0, 1'b0, 1100, "R6 duty zero low");

    // R7: deferred duty update
    wr(2'd1, 8'd100);
    expect_wave(0, 400, 1024, "R7 duty 100");
    wait_rise(0, ok);
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'd20;
    hi = ok ? 1 : 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (pin(0)) hi++;
      else break;
    end
    chk("R7 running period keeps old duty", hi, 400);
    expect_wave(0, 80, 1024, "R7 next period new duty");

    // R3: external clock source
    ext_run = 1'b1;
    wr(2'd1, 8'd100);
    wr(2'd0, 8'h07);
    expect_wave(0, 600, 1536, "R3 external ticks");
    ext_run = 1'b0;

    // R10: clock output of code 2
    wr(2'd0, 8'h0A);
    expect_wave(0, 4, 8, "R10 clock out div8");

    // R9 / R8: overrides
    wr(2'd3, 8'h03);
    hold(0, 1'b1, 200, "R9 force high over clock");
    wr(2'd3, 8'h01);
    hold(0, 1'b0, 200, "R8 force A low");
    wr(2'd3, 8'h0C);
    hold(1, 1'b1, 200, "R8 force B high");

    // R5: slow mode, divide by 2
    wr(2'd3, 8'h00);
    wr(2'd1, 8'd2);
    wr(2'd0, 8'h10);
    expect_wave(0, 512, 65536, "R5 slow duty 2");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule